// File: doc/BRIEF.md
# Peripheral Control and Status Register Slave

This block is an AXI4-Lite slave that holds the registers a small peripheral core uses to talk to software. It has four registers, each with its own access type. The control register is read-write and holds an enable, an interrupt enable and a two-bit operating mode. The status register is read-only and reports a busy flag that the core drives. The interrupt register is write-one-to-clear, and the core sets its single flag with a pulse. The data register is write-only, and the core sees the last value written to it.

Every field appears on a port of its own, so the core needs no decoding. Each writable register also has a one-cycle pulse that fires when a bus write to it completes. A core can use the data register's pulse to take a word into its own pipeline.

The write address and write data channels are captured independently. The register update takes place one cycle after both are held. Reads return registered data one cycle after the address handshake. Only one transaction per direction is in flight at a time.

Top module: `csr_axil_regs`

## Requirements
- R1: While reset is low and in the first cycle after it is released, all register fields, write pulses, BVALID and RVALID are 0, and AWREADY, WREADY and ARREADY are 1.
- R2: The control register (word offset 0x00) places enable at bit 0, interrupt enable at bit 1 and mode at bits 3:2, where 0 is idle, 1 is run and 2 is loopback. It reads back with bits 31:4 at 0, and its field ports change only together with its write pulse.
- R3: A write updates only the byte lanes whose WSTRB bit is 1. A write to the control register with WSTRB[0]=0 leaves every control field unchanged.
- R4: A read of the status register (0x04) returns the busy input in bit 0 and 0 in every other bit. A write to it responds OKAY and changes no output.
- R5: The interrupt flag (bit 0 of 0x08) goes to 1 in the cycle after a set pulse and then stays at 1. A write with data bit 0 at 1 (and WSTRB[0] at 1) clears it. A write with data bit 0 at 0 leaves it unchanged.
- R6: When a set pulse occurs in the same cycle as a clearing write, the flag is 1 afterwards.
- R7: A write to the data register (0x0C) drives the written value on its output port. A read of 0x0C returns 0 with OKAY.
- R8: A completed write to the control, interrupt or data register raises that register's pulse for exactly one cycle, in the same cycle that BVALID rises. At most one pulse is high at a time.
- R9: A read or write at an address whose word index is above 3 gets SLVERR (response code 2'b10). The read returns data 0. The write changes no register and raises no pulse. OKAY is 2'b00.
- R10: AW and W may arrive in either order. BVALID rises one cycle after the later of the two is captured and stays high until BREADY. While BVALID is high, AWREADY and WREADY are 0.
- R11: RVALID rises in the cycle after the AR handshake. RVALID and RDATA then hold until RREADY, and ARREADY is 0 while RVALID is high.
- R12: Address bits [1:0] are ignored during decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| ctl_enable | output | 1 | Core enable field |
| ctl_irq_en | output | 1 | Interrupt enable field |
| ctl_mode | output | 2 | Operating mode field |
| ctl_wr_pulse | output | 1 | Control register written |
| stat_busy | input | 1 | Core busy, shown in the status register |
| irq_done_set | input | 1 | One-cycle set pulse for the interrupt flag |
| irq_done | output | 1 | Interrupt flag |
| irq_wr_pulse | output | 1 | Interrupt register written |
| dat_value | output | 32 | Last value written to the data register |
| dat_wr_pulse | output | 1 | Data register written |

## Verification
Wrong decode or masking state is visible at the ports in the same transaction: a misrouted write moves a field port or fires the wrong pulse in the cycle BVALID rises, and a bad read value or response code appears on the first cycle of RVALID. A lost or stuck flag in the interrupt register shows on irq_done one cycle after the set pulse or the clearing write. A handshake flag that fails to clear either keeps BVALID or RVALID high past the ready handshake or drops it early, so the fault shows within one cycle of the ready.

// File: rtl/csr_axil_pkg.sv
package csr_axil_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam int CTL_W  = 4;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_IE_BIT   = 1;
  localparam int CTL_MODE_LSB = 2;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [2:0] {
    SEL_CTL, SEL_STAT, SEL_IRQ, SEL_DATA, SEL_NONE
  } csr_sel_e;

  // word index from bits above [1:0]; only indices 0..3 are mapped
  function automatic csr_sel_e csr_decode(input logic [31:0] addr);
    if (addr[31:4] != '0) return SEL_NONE;
    case (addr[3:2])
      2'd0:    return SEL_CTL;
      2'd1:    return SEL_STAT;
      2'd2:    return SEL_IRQ;
      default: return SEL_DATA;
    endcase
  endfunction

  function automatic logic [1:0] csr_resp(input csr_sel_e sel);
    return (sel == SEL_NONE) ? RESP_SLVERR : RESP_OKAY;
  endfunction

  function automatic logic [DATA_W-1:0] strb_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int b = 0; b < STRB_W; b++)
      if (strb[b]) r[8*b +: 8] = new_w[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/csr_wr_chan.sv
module csr_wr_chan
  import csr_axil_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              commit,
  output csr_sel_e          commit_sel,
  output logic [DATA_W-1:0] commit_data,
  output logic [STRB_W-1:0] commit_strb
);
  logic              aw_have, w_have;
  logic [ADDR_W-1:0] addr_q;

  assign awready    = !aw_have && !bvalid;
  assign wready     = !w_have && !bvalid;
  assign commit     = aw_have && w_have;
  assign commit_sel = csr_decode(32'(addr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_have     <= 1'b0;
      w_have      <= 1'b0;
      addr_q      <= '0;
      commit_data <= '0;
      commit_strb <= '0;
      bvalid      <= 1'b0;
      bresp       <= RESP_OKAY;
    end else begin
      if (awvalid && awready) begin
        aw_have <= 1'b1;
        addr_q  <= awaddr;
      end
      if (wvalid && wready) begin
        w_have      <= 1'b1;
        commit_data <= wdata;
        commit_strb <= wstrb;
      end
      if (commit) begin
        aw_have <= 1'b0;
        w_have  <= 1'b0;
        bvalid  <= 1'b1;
        bresp   <= csr_resp(commit_sel);
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/csr_rd_chan.sv
module csr_rd_chan
  import csr_axil_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic              ar_fire,
  output csr_sel_e          rd_sel,
  input  logic [DATA_W-1:0] rd_word
);
  assign arready = !rvalid;
  assign ar_fire = arvalid && arready;
  assign rd_sel  = csr_decode(32'(araddr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      rresp  <= RESP_OKAY;
    end else if (ar_fire) begin
      rvalid <= 1'b1;
      rdata  <= rd_word;
      rresp  <= csr_resp(rd_sel);
    end else if (rvalid && rready) begin
      rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/csr_reg_bank.sv
module csr_reg_bank
  import csr_axil_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  csr_sel_e          commit_sel,
  input  logic [DATA_W-1:0] commit_data,
  input  logic [STRB_W-1:0] commit_strb,
  input  csr_sel_e          rd_sel,
  output logic [DATA_W-1:0] rd_word,
  input  logic              stat_busy,
  input  logic              irq_done_set,
  output logic [CTL_W-1:0]  ctl_q,
  output logic              irq_done,
  output logic [DATA_W-1:0] dat_q,
  output logic              ctl_pulse,
  output logic              irq_pulse,
  output logic              dat_pulse
);
  logic wr_ctl, wr_irq, wr_dat, irq_clr;

  assign wr_ctl  = commit && (commit_sel == SEL_CTL);
  assign wr_irq  = commit && (commit_sel == SEL_IRQ);
  assign wr_dat  = commit && (commit_sel == SEL_DATA);
  assign irq_clr = wr_irq && commit_strb[0] && commit_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      irq_done  <= 1'b0;
      dat_q     <= '0;
      ctl_pulse <= 1'b0;
      irq_pulse <= 1'b0;
      dat_pulse <= 1'b0;
    end else begin
      if (wr_ctl && commit_strb[0]) ctl_q <= commit_data[CTL_W-1:0];
      if (wr_dat) dat_q <= strb_merge(dat_q, commit_data, commit_strb);
      // hardware set has priority over the software clear
      irq_done  <= irq_done_set || (irq_done && !irq_clr);
      ctl_pulse <= wr_ctl;
      irq_pulse <= wr_irq;
      dat_pulse <= wr_dat;
    end
  end

  always_comb begin
    rd_word = '0;
    case (rd_sel)
      SEL_CTL:  rd_word[CTL_W-1:0] = ctl_q;
      SEL_STAT: rd_word[0] = stat_busy;
      SEL_IRQ:  rd_word[0] = irq_done;
      default:  rd_word = '0;
    endcase
  end
endmodule

// File: rtl/csr_axil_regs.sv
module csr_axil_regs
  import csr_axil_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              ctl_enable,
  output logic              ctl_irq_en,
  output logic [1:0]        ctl_mode,
  output logic              ctl_wr_pulse,
  input  logic              stat_busy,
  input  logic              irq_done_set,
  output logic              irq_done,
  output logic              irq_wr_pulse,
  output logic [31:0]       dat_value,
  output logic              dat_wr_pulse
);
  logic              wr_commit;
  csr_sel_e          wr_sel;
  logic [DATA_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic              ar_fire;
  csr_sel_e          rd_sel;
  logic [DATA_W-1:0] rd_word;
  logic [CTL_W-1:0]  ctl_q;

  csr_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .commit(wr_commit), .commit_sel(wr_sel),
    .commit_data(wr_data), .commit_strb(wr_strb)
  );

  csr_rd_chan #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .ar_fire(ar_fire), .rd_sel(rd_sel), .rd_word(rd_word)
  );

  csr_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .commit(wr_commit), .commit_sel(wr_sel),
    .commit_data(wr_data), .commit_strb(wr_strb),
    .rd_sel(rd_sel), .rd_word(rd_word),
    .stat_busy(stat_busy), .irq_done_set(irq_done_set),
    .ctl_q(ctl_q), .irq_done(irq_done), .dat_q(dat_value),
    .ctl_pulse(ctl_wr_pulse), .irq_pulse(irq_wr_pulse), .dat_pulse(dat_wr_pulse)
  );

  assign ctl_enable = ctl_q[CTL_EN_BIT];
  assign ctl_irq_en = ctl_q[CTL_IE_BIT];
  assign ctl_mode   = ctl_q[CTL_MODE_LSB +: 2];
endmodule

// File: rtl/csr_axil_chk.sv
module csr_axil_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_awready,
  input logic        s_wready,
  input logic        s_bvalid,
  input logic        s_bready,
  input logic        s_arready,
  input logic        s_rvalid,
  input logic        s_rready,
  input logic [31:0] s_rdata,
  input logic        ctl_enable,
  input logic        ctl_irq_en,
  input logic [1:0]  ctl_mode,
  input logic        ctl_wr_pulse,
  input logic        irq_done_set,
  input logic        irq_done,
  input logic        irq_wr_pulse,
  input logic [31:0] dat_value,
  input logic        dat_wr_pulse,
  input logic        wr_commit,
  input logic        ar_fire
);
  // R10
  bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);
  // R10
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> !s_awready && !s_wready);
  // R11
  rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  // R11
  rvalid_after_ar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |=> s_rvalid);
  // R11
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> !s_arready);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done_set |=> irq_done);
  // R5
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> $past(irq_done_set));
  // R8
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_wr_pulse, irq_wr_pulse, dat_wr_pulse}));
  // R8
  pulse_with_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_pulse || irq_wr_pulse || dat_wr_pulse) |-> $past(wr_commit) && s_bvalid);
  // R2
  ctl_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ctl_enable, ctl_irq_en, ctl_mode}) |-> ctl_wr_pulse);
  // R7
  dat_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dat_value) |-> dat_wr_pulse);
endmodule

bind csr_axil_regs csr_axil_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_awready(s_awready), .s_wready(s_wready),
  .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_arready(s_arready), .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
  .ctl_enable(ctl_enable), .ctl_irq_en(ctl_irq_en), .ctl_mode(ctl_mode),
  .ctl_wr_pulse(ctl_wr_pulse), .irq_done_set(irq_done_set), .irq_done(irq_done),
  .irq_wr_pulse(irq_wr_pulse), .dat_value(dat_value), .dat_wr_pulse(dat_wr_pulse),
  .wr_commit(wr_commit), .ar_fire(ar_fire)
);

// File: tb/tb_csr_axil_regs.sv
module tb_csr_axil_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam logic [1:0] OKAY = 2'b00;
  localparam logic [1:0] SLVERR = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata, dat_value;
  logic ctl_enable, ctl_irq_en, ctl_wr_pulse, irq_done, irq_wr_pulse, dat_wr_pulse;
  logic [1:0] ctl_mode;
  logic stat_busy = 0, irq_set = 0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_axil_regs #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .ctl_enable(ctl_enable), .ctl_irq_en(ctl_irq_en), .ctl_mode(ctl_mode),
    .ctl_wr_pulse(ctl_wr_pulse), .stat_busy(stat_busy),
    .irq_done_set(irq_set), .irq_done(irq_done), .irq_wr_pulse(irq_wr_pulse),
    .dat_value(dat_value), .dat_wr_pulse(dat_wr_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl_ports();
    return {28'd0, ctl_mode, ctl_irq_en, ctl_enable};
  endfunction

  function automatic logic [2:0] pulses_now();
    return {ctl_wr_pulse, irq_wr_pulse, dat_wr_pulse};
  endfunction

  // order: 0 both together, 1 address first, 2 data first
  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s,
                           input int order, output logic [1:0] resp, output logic [2:0] pls);
    int n;
    @(negedge clk);
    if (order != 2) begin awvalid = 1; awaddr = a; end
    if (order != 1) begin wvalid = 1; wdata = d; wstrb = s; end
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    if (order == 1) begin wvalid = 1; wdata = d; wstrb = s; @(negedge clk); wvalid = 0; end
    if (order == 2) begin awvalid = 1; awaddr = a; @(negedge clk); awvalid = 0; end
    n = 0;
    while (!bvalid && n < 20) begin @(negedge clk); n++; end
    resp = bresp;
    pls = pulses_now();
    bready = 1;
    @(negedge clk);
    bready = 0;
    chk("R8 pulse lasts one cycle", {29'd0, pulses_now()}, 32'd0);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d, output logic [1:0] resp);
    @(negedge clk);
    arvalid = 1; araddr = a;
    @(negedge clk);
    arvalid = 0;
    chk("R11 rvalid one cycle after AR", {31'd0, rvalid}, 32'd1);
    d = rdata; resp = rresp;
    rready = 1;
    @(negedge clk);
    rready = 0;
    chk("R11 rvalid drops after RREADY", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 ready lines", {29'd0, awready, wready, arready}, 32'd7);
    chk("R1 valid lines", {30'd0, bvalid, rvalid}, 32'd0);
    chk("R1 control fields", ctl_ports(), 32'd0);
    chk("R1 irq flag", {31'd0, irq_done}, 32'd0);
    chk("R1 data value", dat_value, 32'd0);
    chk("R1 pulses", {29'd0, pulses_now()}, 32'd0);
  endtask

  task automatic t_control();
    logic [1:0] r; logic [2:0] p; logic [31:0] d;
    bus_write(8'h00, 32'hFFFF_FFFF, 4'hF, 0, r, p);
    chk("R2 write resp", {30'd0, r}, {30'd0, OKAY});
    chk("R8 only control pulse", {29'd0, p}, 32'b100);
    chk("R2 all fields set", ctl_ports(), 32'hF);
    bus_read(8'h00, d, r);
    chk("R2 readback masks upper bits", d, 32'h0000_000F);
    bus_write(8'h00, 32'h0000_0006, 4'hF, 0, r, p);
    chk("R2 enable=0 irq_en=1 mode=run", ctl_ports(), 32'h6);
    bus_write(8'h00, 32'h0000_0009, 4'hF, 0, r, p);
    chk("R2 mode=loopback with enable", ctl_ports(), 32'h9);
  endtask

  task automatic t_strobes();
    logic [1:0] r; logic [2:0] p;
    bus_write(8'h0C, 32'h1122_3344, 4'hF, 0, r, p);
    bus_write(8'h0C, 32'hAABB_CCDD, 4'b0101, 0, r, p);
    chk("R3 partial lanes on data", dat_value, 32'h11BB_33DD);
    bus_write(8'h00, 32'h0000_0006, 4'b1110, 0, r, p);
    chk("R3 control untouched without lane 0", ctl_ports(), 32'h9);
  endtask

  task automatic t_status();
    logic [1:0] r; logic [2:0] p; logic [31:0] d;
    stat_busy = 1;
    bus_read(8'h04, d, r);
    chk("R4 busy reads 1", d, 32'd1);
    chk("R4 read resp", {30'd0, r}, {30'd0, OKAY});
    bus_read(8'h06, d, r);
    chk("R12 low address bits ignored on read", d, 32'd1);
    stat_busy = 0;
    bus_read(8'h04, d, r);
    chk("R4 busy reads 0", d, 32'd0);
    bus_write(8'h04, 32'hFFFF_FFFF, 4'hF, 0, r, p);
    chk("R4 write resp OKAY", {30'd0, r}, {30'd0, OKAY});
    chk("R4 write makes no pulse", {29'd0, p}, 32'd0);
    chk("R4 control unchanged", ctl_ports(), 32'h9);
    chk("R4 data unchanged", dat_value, 32'h11BB_33DD);
    bus_write(8'h03, 32'h0000_0004, 4'hF, 0, r, p);
    chk("R12 low address bits ignored on write", ctl_ports(), 32'h4);
  endtask

  task automatic t_irq();
    logic [1:0] r; logic [2:0] p; logic [31:0] d;
    @(negedge clk); irq_set = 1;
    @(negedge clk); irq_set = 0;
    chk("R5 flag set by pulse", {31'd0, irq_done}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R5 flag stays set", {31'd0, irq_done}, 32'd1);
    bus_write(8'h08, 32'h0000_0000, 4'hF, 0, r, p);
    chk("R5 writing 0 keeps flag", {31'd0, irq_done}, 32'd1);
    bus_read(8'h08, d, r);
    chk("R5 flag reads back", d, 32'd1);
    bus_write(8'h08, 32'h0000_0001, 4'hF, 0, r, p);
    chk("R8 only irq pulse", {29'd0, p}, 32'b010);
    chk("R5 writing 1 clears flag", {31'd0, irq_done}, 32'd0);
  endtask

  task automatic t_set_wins();
    @(negedge clk); irq_set = 1;
    @(negedge clk); irq_set = 0;
    @(negedge clk);
    awvalid = 1; awaddr = 8'h08; wvalid = 1; wdata = 32'h1; wstrb = 4'hF;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    irq_set = 1;
    @(negedge clk);
    irq_set = 0;
    chk("R6 set beats clear", {31'd0, irq_done}, 32'd1);
    chk("R10 bvalid with the commit", {31'd0, bvalid}, 32'd1);
    bready = 1;
    @(negedge clk);
    bready = 0;
    chk("R6 flag holds after", {31'd0, irq_done}, 32'd1);
  endtask

  task automatic t_data();
    logic [1:0] r; logic [2:0] p; logic [31:0] d;
    bus_write(8'h0C, 32'hCAFE_F00D, 4'hF, 0, r, p);
    chk("R7 value on port", dat_value, 32'hCAFE_F00D);
    chk("R8 only data pulse", {29'd0, p}, 32'b001);
    bus_read(8'h0C, d, r);
    chk("R7 read returns 0", d, 32'd0);
    chk("R7 read resp OKAY", {30'd0, r}, {30'd0, OKAY});
  endtask

  task automatic t_unmapped();
    logic [1:0] r; logic [2:0] p; logic [31:0] d;
    bus_write(8'h10, 32'hFFFF_FFFF, 4'hF, 0, r, p);
    chk("R9 write SLVERR", {30'd0, r}, {30'd0, SLVERR});
    chk("R9 write no pulse", {29'd0, p}, 32'd0);
    chk("R9 control unchanged", ctl_ports(), 32'h4);
    chk("R9 data unchanged", dat_value, 32'hCAFE_F00D);
    bus_write(8'hFC, 32'h0, 4'hF, 0, r, p);
    chk("R9 high write SLVERR", {30'd0, r}, {30'd0, SLVERR});
    bus_read(8'h10, d, r);
    chk("R9 read SLVERR", {30'd0, r}, {30'd0, SLVERR});
    chk("R9 read data 0", d, 32'd0);
  endtask

  task automatic t_handshake();
    logic [1:0] r; logic [2:0] p;
    bus_write(8'h0C, 32'h0000_0A01, 4'hF, 1, r, p);
    chk("R10 address first completes", dat_value, 32'h0000_0A01);
    chk("R10 address first resp", {30'd0, r}, {30'd0, OKAY});
    bus_write(8'h0C, 32'h0000_0B02, 4'hF, 2, r, p);
    chk("R10 data first completes", dat_value, 32'h0000_0B02);
    @(negedge clk);
    awvalid = 1; awaddr = 8'h0C; wvalid = 1; wdata = 32'h5A5A_5A5A; wstrb = 4'hF;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    @(negedge clk);
    chk("R10 bvalid after commit", {31'd0, bvalid}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 bvalid held", {31'd0, bvalid}, 32'd1);
      chk("R10 no accept while pending", {30'd0, awready, wready}, 32'd0);
    end
    bready = 1;
    @(negedge clk);
    bready = 0;
    chk("R10 bvalid released", {31'd0, bvalid}, 32'd0);
    chk("R10 held write landed", dat_value, 32'h5A5A_5A5A);
  endtask

  task automatic t_read_hold();
    stat_busy = 1;
    @(negedge clk);
    arvalid = 1; araddr = 8'h04;
    @(negedge clk);
    arvalid = 0;
    stat_busy = 0;
    chk("R11 rvalid raised", {31'd0, rvalid}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 rvalid held", {31'd0, rvalid}, 32'd1);
      chk("R11 rdata stable", rdata, 32'd1);
      chk("R11 no AR accept", {31'd0, arready}, 32'd0);
    end
    rready = 1;
    @(negedge clk);
    rready = 0;
    chk("R11 rvalid released", {31'd0, rvalid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_control();
    t_strobes();
    t_status();
    t_irq();
    t_set_wins();
    t_data();
    t_unmapped();
    t_handshake();
    t_read_hold();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule